// File: doc/BRIEF.md
# Status Register with Block-Lock Write Gating

This block keeps the eight-bit status register of a serial memory and decides, every cycle, whether an array write or a status write may start. Three bits are volatile: a busy bit, a write-enable latch and a general-purpose flag. Five bits are persistent: a two-bit lock level, a two-bit watchdog-period select and a protect-enable bit. Here the persistent bits are ordinary flip-flops with reset values set by parameters.

A command decoder in front of the block supplies one-cycle strobes. These are enable-writes, disable-writes, set-flag, clear-flag, array-write-start, status-write-start and write-done. The decoder also supplies the write-protect pin level, the target array address and the status data byte. The block presents two combinational permission outputs and the register byte. A start strobe is taken only when its permission output is high in the same cycle. A taken start holds the busy bit until the write-done strobe arrives. All control pins are plain level or strobe signals. There is no valid/ready stream, because no data flows through the block.

Register layout: bit 0 busy, bit 1 write-enable latch, bits 3:2 lock level, bits 5:4 watchdog select, bit 6 flag, bit 7 protect-enable.

Top module: `sr_status_ctl`

## Requirements
- R1: After reset, the status byte reads 0x00. The persistent bits take their parameter defaults, which are all 0.
- R2: An enable strobe sets bit 1 and a disable strobe clears it. When both arrive in the same cycle, the disable wins.
- R3: A set-flag strobe sets bit 6 and a clear-flag strobe clears it. When both arrive in the same cycle, the clear wins. A status write never changes bit 6.
- R4: A start that is taken sets bit 0 on the next edge. Bit 0 stays 1 until a write-done strobe. That strobe clears both bit 0 and bit 1 on the next edge. A write-done strobe while bit 0 is 0 has no effect.
- R5: The array-write permission is high exactly when bit 1 is 1, bit 0 is 0, and the address is not locked.
- R6: The lock level in bits 3:2 maps as follows. 00 locks nothing. 01 locks addresses whose top two bits are 11. 10 locks addresses whose top bit is 1. 11 locks every address.
- R7: When bit 7 is 1 and the active-low write-protect pin is low, the status-write permission is low.
- R8: When bit 7 is 0, the write-protect pin level does not affect the status-write permission.
- R9: A taken status write captures its data at the start. The new bits 7 and 5:2 appear on the edge of its write-done strobe, even if the write-protect pin falls while the write is running. Persistent bits change at no other time.
- R10: A status write whose data bits 1:0 are not 00 is refused. Its permission output is low.
- R11: If array and status starts are both strobed with permission in the same cycle, only the array write is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Enable-writes strobe |
| cmd_wrdi | input | 1 | Disable-writes strobe |
| cmd_flag_set | input | 1 | Set-flag strobe |
| cmd_flag_clr | input | 1 | Clear-flag strobe |
| arr_wr_go | input | 1 | Array write start strobe |
| arr_addr | input | ADDR_W | Target array address |
| sts_wr_go | input | 1 | Status write start strobe |
| sts_wr_data | input | 8 | Status write data byte |
| wr_done | input | 1 | Internal write finished strobe |
| status_byte | output | 8 | Current register contents |
| arr_wr_ok | output | 1 | Array write may start |
| sts_wr_ok | output | 1 | Status write may start |

## Verification
The hardest situation to reach is a status write that is already running when protection would now forbid it. Reaching it takes several steps in order. The stimulus first runs a status write that sets bit 7. It then sets the latch again and starts a second status write while the pin is high. It drops the pin before the done strobe, and checks that the new lock and watchdog bits still land. Random command traffic follows, with the pin, the lock level and the address spread across all quarters. Every cycle is compared against a behavioural model.

// File: rtl/sr_pkg.sv
package sr_pkg;
  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_lvl_e;

  typedef struct packed {
    logic      wpen;
    logic [1:0] wd;
    lock_lvl_e  bl;
  } persist_t;

  localparam int BIT_BUSY = 0;
  localparam int BIT_WEL  = 1;
  localparam int BIT_FLAG = 6;
endpackage

// File: rtl/sr_lock_map.sv
module sr_lock_map
  import sr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  lock_lvl_e           lvl,
  input  logic [ADDR_W-1:0]   addr,
  output logic                locked
);
  localparam int TOP = ADDR_W - 1;

  logic [1:0] quarter;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign quarter = addr[TOP -: 2];
    end else begin : g_narrow
      assign quarter = {addr[0], addr[0]};
    end
  endgenerate

  always_comb begin
    unique case (lvl)
      LOCK_NONE: locked = 1'b0;
      LOCK_QTR:  locked = (quarter == 2'b11);
      LOCK_HALF: locked = quarter[1];
      default:   locked = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_volatile.sv
module sr_volatile (
  input  logic clk,
  input  logic rst_n,
  input  logic wren,
  input  logic wrdi,
  input  logic fset,
  input  logic fclr,
  input  logic start,
  input  logic done,
  output logic busy,
  output logic wel,
  output logic flag
);
  logic finish;
  assign finish = done & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      wel  <= 1'b0;
      flag <= 1'b0;
    end else begin
      if (finish)     busy <= 1'b0;
      else if (start) busy <= 1'b1;

      if (finish || wrdi) wel <= 1'b0;
      else if (wren)      wel <= 1'b1;

      if (fclr)      flag <= 1'b0;
      else if (fset) flag <= 1'b1;
    end
  end

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);
  // R4
  done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && done |=> !busy && !wel);
  // R2
  wrdi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrdi |=> !wel);
  // R3
  fclr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fclr |=> !flag);
endmodule

// File: rtl/sr_persist.sv
module sr_persist
  import sr_pkg::*;
#(
  parameter logic [1:0] BL_RST   = 2'b00,
  parameter logic [1:0] WD_RST   = 2'b00,
  parameter logic       WPEN_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [7:0] data,
  input  logic       done,
  input  logic       busy,
  output persist_t   q
);
  localparam persist_t RST_VAL = '{wpen: WPEN_RST, wd: WD_RST, bl: lock_lvl_e'(BL_RST)};

  persist_t held;
  logic     pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= RST_VAL;
      held <= RST_VAL;
      pend <= 1'b0;
    end else begin
      if (accept) begin
        held <= '{wpen: data[7], wd: data[5:4], bl: lock_lvl_e'(data[3:2])};
        pend <= 1'b1;
      end else if (done && busy) begin
        pend <= 1'b0;
        if (pend) q <= held;
      end
    end
  end

  // R9
  persist_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(q));
endmodule

// File: rtl/sr_status_ctl.sv
module sr_status_ctl
  import sr_pkg::*;
#(
  parameter int         ADDR_W   = 16,
  parameter logic [1:0] BL_RST   = 2'b00,
  parameter logic [1:0] WD_RST   = 2'b00,
  parameter logic       WPEN_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_flag_set,
  input  logic              cmd_flag_clr,
  input  logic              arr_wr_go,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              sts_wr_go,
  input  logic [7:0]        sts_wr_data,
  input  logic              wr_done,
  output logic [7:0]        status_byte,
  output logic              arr_wr_ok,
  output logic              sts_wr_ok
);
  logic     busy, wel, flag, locked, pin_block;
  logic     arr_take, sts_take;
  persist_t pq;

  sr_lock_map #(.ADDR_W(ADDR_W)) u_map (
    .lvl(pq.bl), .addr(arr_addr), .locked(locked)
  );

  assign pin_block = pq.wpen & ~wp_n;
  assign arr_wr_ok = wel & ~busy & ~locked;
  assign sts_wr_ok = wel & ~busy & ~pin_block & (sts_wr_data[1:0] == 2'b00);
  assign arr_take  = arr_wr_go & arr_wr_ok;
  assign sts_take  = sts_wr_go & sts_wr_ok & ~arr_take;

  sr_volatile u_vol (
    .clk(clk), .rst_n(rst_n),
    .wren(cmd_wren), .wrdi(cmd_wrdi),
    .fset(cmd_flag_set), .fclr(cmd_flag_clr),
    .start(arr_take | sts_take), .done(wr_done),
    .busy(busy), .wel(wel), .flag(flag)
  );

  sr_persist #(.BL_RST(BL_RST), .WD_RST(WD_RST), .WPEN_RST(WPEN_RST)) u_per (
    .clk(clk), .rst_n(rst_n),
    .accept(sts_take), .data(sts_wr_data),
    .done(wr_done), .busy(busy), .q(pq)
  );

  assign status_byte = {pq.wpen, flag, pq.wd, pq.bl, wel, busy};

  // R7
  wp_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[7] && !wp_n |-> !sts_wr_ok);
  // R6
  all_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[3:2] == 2'b11 |-> !arr_wr_ok);
  // R5
  busy_refuses_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[0] |-> !arr_wr_ok && !sts_wr_ok);
  // R10
  low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr_data[1:0] != 2'b00 |-> !sts_wr_ok);
  // R4
  take_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_go && arr_wr_ok |=> status_byte[0]);
endmodule

// File: tb/sr_status_ctl_bench.sv
module sr_status_ctl_bench;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wp_n = 1'b1, wren = 0, wrdi = 0, fset = 0, fclr = 0;
  logic arr_go = 0, sts_go = 0, done = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0] sdata = '0;
  logic [7:0] st;
  logic aok, sok;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  int m_busy = 0, m_wel = 0, m_flag = 0, m_bl = 0, m_wd = 0, m_wpen = 0;
  int h_bl = 0, h_wd = 0, h_wpen = 0, m_pend = 0;

  always #2.5 clk = ~clk;

  sr_status_ctl #(.ADDR_W(AW)) u_sr_status_ctl (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_wren(wren), .cmd_wrdi(wrdi), .cmd_flag_set(fset), .cmd_flag_clr(fclr),
    .arr_wr_go(arr_go), .arr_addr(addr), .sts_wr_go(sts_go), .sts_wr_data(sdata),
    .wr_done(done), .status_byte(st), .arr_wr_ok(aok), .sts_wr_ok(sok)
  );

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_byte();
    return (m_wpen << 7) | (m_flag << 6) | (m_wd << 4) | (m_bl << 2) | (m_wel << 1) | m_busy;
  endfunction

  // drive inputs at negedge, compare just after, advance model at posedge
  task automatic tick();
    int locked, eaok, esok, atk, stk, fin;
    #1;
    case (m_bl)
      0: locked = 0;
      1: locked = (addr[AW-1:AW-2] == 2'b11);
      2: locked = addr[AW-1];
      default: locked = 1;
    endcase
    eaok = m_wel && !m_busy && !locked;
    esok = m_wel && !m_busy && !(m_wpen && !wp_n) && (sdata[1:0] == 0);
    chk("status_byte", st, m_byte());
    chk("arr_wr_ok", aok, eaok);
    chk("sts_wr_ok", sok, esok);
    atk = arr_go && eaok;
    stk = sts_go && esok && !atk;
    fin = done && m_busy;
    @(posedge clk);
    if (fin) begin
      m_busy = 0;
      if (m_pend) begin m_bl = h_bl; m_wd = h_wd; m_wpen = h_wpen; end
      m_pend = 0;
    end else if (atk || stk) m_busy = 1;
    if (stk) begin
      h_bl = sdata[3:2]; h_wd = sdata[5:4]; h_wpen = sdata[7]; m_pend = 1;
    end
    if (fin || wrdi) m_wel = 0; else if (wren) m_wel = 1;
    if (fclr) m_flag = 0; else if (fset) m_flag = 1;
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle();
    wren = 0; wrdi = 0; fset = 0; fclr = 0; arr_go = 0; sts_go = 0; done = 0;
  endtask

  task automatic stswrite(input logic [7:0] d);
    idle(); wren = 1; tick();
    idle(); sdata = d; sts_go = 1; tick();
    idle(); tick();
    done = 1; tick(); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1"; tick();
    rst_n = 1; tick();
    tag = "R2"; wren = 1; tick(); idle(); tick();
    wren = 1; wrdi = 1; tick(); idle(); tick();
    tag = "R3"; fset = 1; tick(); fset = 1; fclr = 1; tick(); fset = 1; tick(); idle();
    tag = "R5"; wren = 1; tick(); idle(); addr = 16'hF000; arr_go = 1; tick(); idle(); tick();
    tag = "R4"; done = 1; tick(); idle(); done = 1; tick(); idle(); tick();
    tag = "R6"; stswrite(8'b0000_0100);
    wren = 1; tick(); idle();
    addr = 16'hC000; tick(); addr = 16'hBFFF; tick(); addr = 16'h0001; tick();
    stswrite(8'b0000_1000); wren = 1; tick(); idle();
    addr = 16'h8000; tick(); addr = 16'h7FFF; tick();
    stswrite(8'b0000_1100); wren = 1; tick(); idle(); addr = 16'h0000; tick();
    tag = "R10"; sdata = 8'h01; tick(); sdata = 8'h02; tick(); sdata = 8'h00; tick();
    tag = "R8"; wp_n = 0; tick(); wp_n = 1; tick();
    tag = "R11"; stswrite(8'b0011_0000); wren = 1; tick(); idle();
    addr = 16'h1000; arr_go = 1; sts_go = 1; sdata = 8'h3C; tick(); idle(); done = 1; tick(); idle(); tick();
    tag = "R9"; stswrite(8'b1000_0100);
    wren = 1; tick(); idle(); wp_n = 0; tick(); wp_n = 1; tick();
    sdata = 8'b1010_1000; sts_go = 1; tick(); idle();
    wp_n = 0; tick(); done = 1; tick(); idle(); tick();
    tag = "R7"; wren = 1; tick(); idle(); wp_n = 0; sdata = 8'h00; sts_go = 1; tick(); idle(); tick();
    wp_n = 1; tick();
    tag = "R3"; fset = 1; tick(); idle(); stswrite(8'h00); tick();
    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      idle();
      wren = (r < 25); wrdi = (r > 92);
      fset = ($urandom_range(0, 9) == 0); fclr = ($urandom_range(0, 9) == 0);
      arr_go = ($urandom_range(0, 3) == 0); sts_go = ($urandom_range(0, 3) == 0);
      done = ($urandom_range(0, 3) == 0);
      wp_n = ($urandom_range(0, 2) != 0);
      addr = AW'($urandom);
      sdata = ($urandom_range(0, 3) == 0) ? 8'($urandom) : {8'($urandom)} & 8'hFC;
      tick();
    end
    idle(); tick();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule